// File: doc/BRIEF.md
# ADD Instruction Micro-op Cracker

This block sits after the instruction decoder of a processor that runs a complex instruction set on a simple execution core. It takes one decoded ADD instruction at a time and turns it into a short sequence of simple micro-ops. The instruction arrives over a valid/ready handshake and carries an operand form, a destination register, a source register and a memory address descriptor. The form is one of three: register plus register, register plus memory source, or memory destination plus register. The micro-ops leave one per cycle over a second valid/ready handshake.

Every micro-op has the same small set of fields: a kind, one destination, two sources and an address descriptor. A field that a micro-op does not use is driven to zero. Each micro-op also has a first flag, a last flag and a 2-bit index of its place in the sequence. The memory forms stage their data through one temporary register that no instruction can name, because its number lies just above the architectural register range. The block takes no new instruction until the last micro-op of the current one has been accepted. It does not compute addresses and does not execute anything.

Top module: `add_cracker`

## Requirements
- R1: After a synchronous reset, outValid is 0 and inReady is 1.
- R2: The register-register form (inForm = 0) produces exactly one micro-op: kind ALU (code 0), destination = inDst, source A = inDst, source B = inSrc, address 0.
- R3: The memory-source form (inForm = 1) produces two micro-ops. The first is a LOAD (code 1) into the temporary register (number 2**REG_W) from inAddr. The second is an ALU op with destination = inDst, source A = inDst, source B = the temporary.
- R4: The memory-destination form (inForm = 2) produces four micro-ops. They are: a LOAD of the temporary from inAddr; an ALU op with destination = source A = the temporary and source B = inSrc; a store-address micro-op (code 2) carrying inAddr; and a store-data micro-op (code 3) with source A = the temporary.
- R5: Every micro-op field not named for that micro-op in R2 to R4 is zero. Architectural register numbers appear zero-extended by one bit.
- R6: While outValid is 1 and outReady is 0, all micro-op outputs stay unchanged into the next cycle.
- R7: inReady is 0 whenever outValid is 1. After the last micro-op is accepted, the next cycle shows outValid 0 and inReady 1. Input fields and inValid that change during a sequence have no effect on the micro-ops being emitted.
- R8: outFirst is 1 only on the micro-op with index 0. outLast is 1 only on the final micro-op. outIdx counts 0, 1, 2, 3 through the sequence.
- R9: A synchronous reset in the middle of a sequence drops the rest of that sequence, and the block returns to the state given in R1.
- R10: The reserved form code 3 is cracked like the register-register form.
- R11: An instruction accepted at a clock edge shows its first micro-op on the outputs after that same edge. With outReady held at 1, each following micro-op appears one cycle after the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Decoded instruction is present |
| inReady | output | 1 | Block can take an instruction |
| inForm | input | 2 | Operand form: 0 reg-reg, 1 memory source, 2 memory destination, 3 reserved |
| inDst | input | REG_W | Destination (or memory-operand partner) register |
| inSrc | input | REG_W | Source register |
| inAddr | input | ADDR_W | Address descriptor for the memory operand |
| outValid | output | 1 | Micro-op is present |
| outReady | input | 1 | Consumer takes the micro-op |
| outOp | output | 2 | Micro-op kind: 0 ALU, 1 LOAD, 2 store-address, 3 store-data |
| outDst | output | REG_W+1 | Micro-op destination register |
| outSrcA | output | REG_W+1 | First source register |
| outSrcB | output | REG_W+1 | Second source register |
| outAddr | output | ADDR_W | Address descriptor |
| outFirst | output | 1 | First micro-op of the instruction |
| outLast | output | 1 | Last micro-op of the instruction |
| outIdx | output | 2 | Position in the sequence |

## Verification
An instruction accepted at a rising edge shows micro-op 0 right after that edge. Each accepted micro-op is replaced by the next one at the following edge. inReady comes back one cycle after the edge that accepts the last micro-op. The bench drives and samples on the falling edge, so every check reads a value that one rising edge has settled. During stalls it samples the held micro-op on two falling edges in a row. After a mid-sequence reset, it looks for the idle state at the first falling edge after the reset edge.

// File: rtl/addcrack_pkg.sv
package addcrack_pkg;
  typedef enum logic [1:0] {
    UOP_ALU    = 2'd0,
    UOP_LOAD   = 2'd1,
    UOP_STADDR = 2'd2,
    UOP_STDATA = 2'd3
  } uopKind_e;

  localparam logic [1:0] FORM_REG  = 2'd0;
  localparam logic [1:0] FORM_MSRC = 2'd1;
  localparam logic [1:0] FORM_MDST = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic [1:0] step;
  } crackCtl_t;

  function automatic logic [1:0] lastStepOf(input logic [1:0] form);
    case (form)
      FORM_MSRC: return 2'd1;
      FORM_MDST: return 2'd3;
      default:   return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/addcrack_ctrl.sv
module addcrack_ctrl
  import addcrack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] inForm,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       outFirst,
  output logic       outLast,
  output logic [1:0] outIdx,
  output crackCtl_t  ctl
);
  logic       busy;
  logic [1:0] step;
  logic [1:0] lastStep;
  logic       accept;
  logic       fire;

  assign accept = inValid && !busy;
  assign fire   = busy && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step     <= 2'd0;
      lastStep <= 2'd0;
    end else if (accept) begin
      busy     <= 1'b1;
      step     <= 2'd0;
      lastStep <= lastStepOf(inForm);
    end else if (fire) begin
      if (step == lastStep) begin
        busy <= 1'b0;
        step <= 2'd0;
      end else begin
        step <= step + 2'd1;
      end
    end
  end

  assign inReady     = !busy;
  assign outValid    = busy;
  assign outFirst    = busy && (step == 2'd0);
  assign outLast     = busy && (step == lastStep);
  assign outIdx      = step;
  assign ctl.capture = accept;
  assign ctl.step    = step;
endmodule

// File: rtl/addcrack_dp.sv
module addcrack_dp
  import addcrack_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  crackCtl_t         ctl,
  input  logic [1:0]        inForm,
  input  logic [REG_W-1:0]  inDst,
  input  logic [REG_W-1:0]  inSrc,
  input  logic [ADDR_W-1:0] inAddr,
  output logic [1:0]        outOp,
  output logic [REG_W:0]    outDst,
  output logic [REG_W:0]    outSrcA,
  output logic [REG_W:0]    outSrcB,
  output logic [ADDR_W-1:0] outAddr
);
  localparam int UREG_W = REG_W + 1;
  localparam logic [UREG_W-1:0] TEMP_REG = {1'b1, {REG_W{1'b0}}};

  logic [1:0]        heldForm;
  logic [UREG_W-1:0] heldDst;
  logic [UREG_W-1:0] heldSrc;
  logic [ADDR_W-1:0] heldAddr;
  uopKind_e          kind;

  always_ff @(posedge clk) begin
    if (ctl.capture) begin
      heldForm <= inForm;
      heldDst  <= {1'b0, inDst};
      heldSrc  <= {1'b0, inSrc};
      heldAddr <= inAddr;
    end
  end

  always_comb begin
    kind    = UOP_ALU;
    outDst  = '0;
    outSrcA = '0;
    outSrcB = '0;
    outAddr = '0;
    case (heldForm)
      FORM_MSRC: begin
        if (ctl.step == 2'd0) begin
          kind    = UOP_LOAD;
          outDst  = TEMP_REG;
          outAddr = heldAddr;
        end else begin
          outDst  = heldDst;
          outSrcA = heldDst;
          outSrcB = TEMP_REG;
        end
      end
      FORM_MDST: begin
        case (ctl.step)
          2'd0: begin
            kind    = UOP_LOAD;
            outDst  = TEMP_REG;
            outAddr = heldAddr;
          end
          2'd1: begin
            outDst  = TEMP_REG;
            outSrcA = TEMP_REG;
            outSrcB = heldSrc;
          end
          2'd2: begin
            kind    = UOP_STADDR;
            outAddr = heldAddr;
          end
          default: begin
            kind    = UOP_STDATA;
            outSrcA = TEMP_REG;
          end
        endcase
      end
      default: begin
        outDst  = heldDst;
        outSrcA = heldDst;
        outSrcB = heldSrc;
      end
    endcase
  end

  assign outOp = kind;
endmodule

// File: rtl/add_cracker.sv
module add_cracker
  import addcrack_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inForm,
  input  logic [REG_W-1:0]  inDst,
  input  logic [REG_W-1:0]  inSrc,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outOp,
  output logic [REG_W:0]    outDst,
  output logic [REG_W:0]    outSrcA,
  output logic [REG_W:0]    outSrcB,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outFirst,
  output logic              outLast,
  output logic [1:0]        outIdx
);
  crackCtl_t ctl;

  addcrack_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inForm   (inForm),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outFirst (outFirst),
    .outLast  (outLast),
    .outIdx   (outIdx),
    .ctl      (ctl)
  );

  addcrack_dp #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .inForm  (inForm),
    .inDst   (inDst),
    .inSrc   (inSrc),
    .inAddr  (inAddr),
    .outOp   (outOp),
    .outDst  (outDst),
    .outSrcA (outSrcA),
    .outSrcB (outSrcB),
    .outAddr (outAddr)
  );
endmodule

// File: rtl/addcrack_chk.sv
module addcrack_chk #(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outOp,
  input logic [REG_W:0]    outDst,
  input logic [REG_W:0]    outSrcA,
  input logic [REG_W:0]    outSrcB,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outFirst,
  input logic              outLast,
  input logic [1:0]        outIdx
);
  localparam logic [REG_W:0] TEMP_REG = {1'b1, {REG_W{1'b0}}};

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid &&
      $stable({outOp, outDst, outSrcA, outSrcB, outAddr, outFirst, outLast, outIdx}));

  assert_busy_blocks_input_R7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  assert_release_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && outLast |=> inReady && !outValid);

  assert_first_is_zero_R8: assert property (@(posedge clk) disable iff (rst)
    outValid && outFirst |-> outIdx == 2'd0);

  assert_index_steps_R8: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !outLast |=> outValid && outIdx == $past(outIdx) + 2'd1);

  assert_single_is_alu_R2: assert property (@(posedge clk) disable iff (rst)
    outValid && outFirst && outLast |-> outOp == 2'd0);

  assert_stdata_uses_temp_R4: assert property (@(posedge clk) disable iff (rst)
    outValid && outOp == 2'd3 |-> outSrcA == TEMP_REG && outLast);

  assert_reset_idles_R9: assert property (@(posedge clk)
    rst |=> !outValid && inReady);
endmodule

bind add_cracker addcrack_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outOp    (outOp),
  .outDst   (outDst),
  .outSrcA  (outSrcA),
  .outSrcB  (outSrcB),
  .outAddr  (outAddr),
  .outFirst (outFirst),
  .outLast  (outLast),
  .outIdx   (outIdx)
);

// File: tb/add_cracker_tb.sv
module add_cracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 4;
  localparam int ADDR_W = 16;
  localparam int NVEC = 10;
  // {form, dst, src, addr, stall index (7 = none)}
  localparam logic [28:0] VECS [NVEC] = '{
    {2'd0, 4'd3, 4'd5, 16'h0000, 3'd7},
    {2'd1, 4'd7, 4'd2, 16'h1234, 3'd7},
    {2'd2, 4'd1, 4'd9, 16'hBEEF, 3'd7},
    {2'd2, 4'd15, 4'd0, 16'hFFFF, 3'd2},
    {2'd1, 4'd0, 4'd15, 16'h8001, 3'd0},
    {2'd3, 4'd6, 4'd12, 16'hA5A5, 3'd7},
    {2'd0, 4'd15, 4'd15, 16'h0F0F, 3'd0},
    {2'd2, 4'd8, 4'd4, 16'h0001, 3'd3},
    {2'd1, 4'd11, 4'd1, 16'h7FFE, 3'd1},
    {2'd2, 4'd2, 4'd13, 16'h5555, 3'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] inForm = '0;
  logic [REG_W-1:0] inDst = '0;
  logic [REG_W-1:0] inSrc = '0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [1:0] outOp;
  logic [REG_W:0] outDst, outSrcA, outSrcB;
  logic [ADDR_W-1:0] outAddr;
  logic outFirst, outLast;
  logic [1:0] outIdx;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  add_cracker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inForm(inForm), .inDst(inDst), .inSrc(inSrc), .inAddr(inAddr),
    .outValid(outValid), .outReady(outReady), .outOp(outOp),
    .outDst(outDst), .outSrcA(outSrcA), .outSrcB(outSrcB),
    .outAddr(outAddr), .outFirst(outFirst), .outLast(outLast), .outIdx(outIdx)
  );

  function automatic logic [36:0] dutUop();
    return {outOp, outDst, outSrcA, outSrcB, outAddr, outFirst, outLast, outIdx};
  endfunction

  function automatic int uopCount(input logic [1:0] form);
    return (form == 2'd1) ? 2 : (form == 2'd2) ? 4 : 1;
  endfunction

  // expected micro-op from R2..R5, R8, R10
  function automatic logic [36:0] expUop(input logic [1:0] form, input logic [3:0] dst,
                                         input logic [3:0] src, input logic [15:0] addr,
                                         input int k);
    logic [1:0] op = 2'd0;
    logic [4:0] d = '0, a = '0, b = '0;
    logic [15:0] ad = '0;
    logic [4:0] tmp = 5'h10;
    int n = uopCount(form);
    if (form == 2'd1) begin
      if (k == 0) begin op = 2'd1; d = tmp; ad = addr; end
      else begin d = {1'b0, dst}; a = {1'b0, dst}; b = tmp; end
    end else if (form == 2'd2) begin
      case (k)
        0: begin op = 2'd1; d = tmp; ad = addr; end
        1: begin d = tmp; a = tmp; b = {1'b0, src}; end
        2: begin op = 2'd2; ad = addr; end
        default: begin op = 2'd3; a = tmp; end
      endcase
    end else begin
      d = {1'b0, dst}; a = {1'b0, dst}; b = {1'b0, src};
    end
    return {op, d, a, b, ad, k == 0, k == n - 1, 2'(k)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sends one instruction and walks its micro-ops; stallAt < 4 holds outReady low there
  task automatic runInstr(input logic [1:0] form, input logic [3:0] dst, input logic [3:0] src,
                          input logic [15:0] addr, input int stallAt, input string req);
    int n = uopCount(form);
    logic [36:0] held;
    @(negedge clk);
    check(inReady === 1'b1, "R7 ready before send", {63'd0, inReady}, 64'd1);
    inValid = 1'b1; inForm = form; inDst = dst; inSrc = src; inAddr = addr;
    @(negedge clk);
    // R7: change inputs mid-sequence, must not matter
    inValid = 1'b0; inForm = ~form; inDst = ~dst; inSrc = ~src; inAddr = ~addr;
    for (int k = 0; k < n; k++) begin
      if (k == stallAt) begin
        outReady = 1'b0;
        held = dutUop();
        @(negedge clk);
        check(outValid === 1'b1 && dutUop() === held, "R6 stall hold", {27'd0, dutUop()}, {27'd0, held});
        outReady = 1'b1;
      end
      check(outValid === 1'b1, {req, " R11 valid"}, {63'd0, outValid}, 64'd1);
      check(inReady === 1'b0, "R7 busy", {63'd0, inReady}, 64'd0);
      check(dutUop() === expUop(form, dst, src, addr, k), {req, " R8 uop"},
            {27'd0, dutUop()}, {27'd0, expUop(form, dst, src, addr, k)});
      @(negedge clk);
    end
    check(outValid === 1'b0 && inReady === 1'b1, "R7 release", {62'd0, outValid, inReady}, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(outValid === 1'b0 && inReady === 1'b1, "R1 reset state", {62'd0, outValid, inReady}, 64'd1);

    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] v = VECS[i];
      string r = (v[28:27] == 2'd0) ? "R2" : (v[28:27] == 2'd1) ? "R3" :
                 (v[28:27] == 2'd2) ? "R4 R5" : "R10";
      runInstr(v[28:27], v[26:23], v[22:19], v[18:3], (v[2:0] == 3'd7) ? 99 : int'(v[2:0]), r);
    end

    // R9: reset in the middle of a memory-destination sequence
    @(negedge clk);
    inValid = 1'b1; inForm = 2'd2; inDst = 4'd3; inSrc = 4'd4; inAddr = 16'h4444;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(outIdx === 2'd1 && outValid === 1'b1, "R9 mid sequence", {62'd0, outIdx}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(outValid === 1'b0 && inReady === 1'b1, "R9 aborted", {62'd0, outValid, inReady}, 64'd1);
    runInstr(2'd0, 4'd9, 4'd10, 16'h0, 99, "R9 after reset R2");

    // R11: back-to-back instructions with inValid held high
    @(negedge clk);
    inValid = 1'b1; inForm = 2'd1; inDst = 4'd5; inSrc = 4'd6; inAddr = 16'h2222;
    @(negedge clk);
    check(outValid === 1'b1 && outOp === 2'd1, "R11 first uop next cycle", {62'd0, outOp}, 64'd1);
    @(negedge clk);
    check(outIdx === 2'd1 && outLast === 1'b1, "R11 second uop", {62'd0, outIdx}, 64'd1);
    @(negedge clk);
    check(inReady === 1'b1 && outValid === 1'b0, "R7 accepts again", {62'd0, inReady, outValid}, 64'd2);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1 && outFirst === 1'b1, "R8 second instr first", {63'd0, outFirst}, 64'd1);
    repeat (2) @(negedge clk);
    check(outValid === 1'b0, "R7 idle at end", {63'd0, outValid}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule